// File: doc/BRIEF.md
# Local interrupt vector dispatcher

This block is the front end that turns local interrupt events of one processor into delivery requests. It keeps a small table of 32-bit local vector entries. Three sources feed it: a timer expiry strobe, a request from a legacy interrupt controller on the LINT0 line, and a LINT1 event strobe. Each entry carries a mask bit, a three-bit delivery mode, a level-trigger bit and an 8-bit vector.

For every event the block looks up the matching entry. Depending on the mode it raises a system-management request, a non-maskable request or an external-interrupt request, or it posts a fixed vector that is tagged edge or level. A request from the legacy controller first passes an acceptance check. Events that arrive in the same cycle are served one per cycle in a fixed order, and the rest wait.

Software reaches the table through a plain synchronous register port. Reset values depend on the processor ID input, so that only processor zero has LINT0 routed to the external-interrupt path after reset.

Top module: `lvt_dispatch`

## Requirements
- R1: An event whose entry has bit 16 (mask) set produces no output pulse of any kind.
- R2: The delivery mode is entry bits 10:8. Mode 3'b010 raises `smi_req`, mode 3'b100 raises `nmi_req` and mode 3'b111 raises `ext_req`. The values 3'b001, 3'b011, 3'b101 and 3'b110 produce no output.
- R3: Each output is a single-cycle pulse in the cycle after the clock edge at which its event is taken. At most one of `smi_req`, `nmi_req`, `ext_req` and `fix_valid` is high in any cycle.
- R4: Mode 3'b000 (fixed) pulses `fix_valid` and drives `fix_vector` with entry bits 7:0. When `fix_valid` is low, `fix_vector` and `fix_level` are zero.
- R5: A fixed delivery sets `fix_level` only when the source is LINT0 or LINT1 and entry bit 15 is set. A timer delivery is always edge (`fix_level` = 0).
- R6: Reset loads every entry with 32'h0001_0000. When `cpu_id` is zero during reset, the LINT0 entry is loaded with 32'h0000_0700 instead.
- R7: A `legacy_req` is accepted only if `glb_en` is 0 or the LINT0 mask bit is 0. A rejected request is dropped and takes no service slot. An accepted request is served through the LINT0 entry decode, even when that entry is masked.
- R8: While `legacy_req` is low, LINT0 produces no delivery.
- R9: Events taken at the same edge are served one per cycle in the order timer, LINT0, LINT1. The events not yet served stay pending.
- R10: The timer entry is at index 0, LINT0 at index 3 and LINT1 at index 4. A write with `wr_en` takes effect at the clock edge. `rd_data` returns the entry at `addr` one cycle after `addr` is presented. Writes during reset are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cpu_id | input | 8 | Processor ID, sampled during reset |
| glb_en | input | 1 | Global enable of the interrupt controller |
| wr_en | input | 1 | Table write enable |
| addr | input | 3 | Table index for write and read |
| wr_data | input | 32 | Write data |
| rd_data | output | 32 | Registered read data |
| tmr_expire | input | 1 | Timer expiry event strobe |
| legacy_req | input | 1 | Legacy controller request on LINT0 |
| lint1_evt | input | 1 | LINT1 event strobe |
| smi_req | output | 1 | System-management request pulse |
| nmi_req | output | 1 | Non-maskable interrupt request pulse |
| ext_req | output | 1 | External-interrupt request pulse |
| fix_valid | output | 1 | Fixed vector post pulse |
| fix_vector | output | 8 | Posted vector |
| fix_level | output | 1 | Trigger tag of the post: 1 level, 0 edge |

## Verification
A sweep covers all eight mode values for each of the three sources, each with the mask and level bits in all four combinations. This separates the decoded modes from the ignored ones and shows that the level tag is honoured for LINT0 and LINT1 but not for the timer. A burst with all three sources in one cycle shows the service order and the holding of pending events. A legacy request paired with a LINT1 event shows whether the request was accepted or dropped: an accepted request takes a slot and delays the LINT1 delivery by one cycle, even when the LINT0 entry is masked. Two resets, with processor ID zero and with a nonzero ID, separate the two LINT0 reset values.

// File: rtl/lvt_pkg.sv
package lvt_pkg;
  typedef enum logic [2:0] {
    DM_FIXED  = 3'b000,
    DM_SMI    = 3'b010,
    DM_NMI    = 3'b100,
    DM_EXTINT = 3'b111
  } dmode_e;

  typedef enum logic [1:0] {
    SRC_TMR   = 2'd0,
    SRC_LINT0 = 2'd1,
    SRC_LINT1 = 2'd2
  } src_e;

  localparam int MASK_BIT  = 16;
  localparam int LEVEL_BIT = 15;
  localparam logic [31:0] ENT_RST    = 32'h0001_0000;
  localparam logic [31:0] LINT0_BOOT = 32'h0000_0700;
endpackage

// File: rtl/lvt_table.sv
module lvt_table
  import lvt_pkg::*;
#(
  parameter int NUM_ENTRIES = 6,
  parameter int ID_W        = 8,
  parameter int TMR_IDX     = 0,
  parameter int LINT0_IDX   = 3,
  parameter int LINT1_IDX   = 4,
  localparam int IDX_W      = $clog2(NUM_ENTRIES)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [ID_W-1:0]  cpu_id,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] addr,
  input  logic [31:0]      wr_data,
  output logic [31:0]      rd_data,
  output logic [31:0]      tmr_ent,
  output logic [31:0]      lint0_ent,
  output logic [31:0]      lint1_ent
);
  logic [31:0] ent_q [NUM_ENTRIES];

  for (genvar i = 0; i < NUM_ENTRIES; i++) begin : g_ent
    always_ff @(posedge clk) begin
      if (rst) begin
        if (i == LINT0_IDX && cpu_id == '0) ent_q[i] <= LINT0_BOOT;
        else                                ent_q[i] <= ENT_RST;
      end else if (wr_en && addr == IDX_W'(i)) begin
        ent_q[i] <= wr_data;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) rd_data <= '0;
    else if (int'(addr) < NUM_ENTRIES) rd_data <= ent_q[addr];
    else rd_data <= '0;
  end

  assign tmr_ent   = ent_q[TMR_IDX];
  assign lint0_ent = ent_q[LINT0_IDX];
  assign lint1_ent = ent_q[LINT1_IDX];
endmodule

// File: rtl/lvt_arbiter.sv
module lvt_arbiter
  import lvt_pkg::*;
#(
  parameter int NUM_SRC = 3
) (
  input  logic clk,
  input  logic rst,
  input  logic tmr_evt,
  input  logic lint0_evt,
  input  logic lint1_evt,
  output logic go,
  output src_e src
);
  logic [NUM_SRC-1:0] pend_q, comb, grant;

  assign comb  = pend_q | {lint1_evt, lint0_evt, tmr_evt};
  assign grant = comb & (~comb + NUM_SRC'(1));
  assign go    = |comb;

  always_comb begin
    if (grant[0])      src = SRC_TMR;
    else if (grant[1]) src = SRC_LINT0;
    else               src = SRC_LINT1;
  end

  always_ff @(posedge clk) begin
    if (rst) pend_q <= '0;
    else     pend_q <= comb & ~grant;
  end

  AST_PENDING_SERVED: assert property (@(posedge clk) disable iff (rst)
    (|pend_q) |-> go); // R9

  AST_TMR_FIRST: assert property (@(posedge clk) disable iff (rst)
    tmr_evt |-> (src == SRC_TMR)); // R9
endmodule

// File: rtl/lvt_decode.sv
module lvt_decode
  import lvt_pkg::*;
(
  input  logic        clk,
  input  logic        rst,
  input  logic        go,
  input  src_e        src,
  input  logic [31:0] entry,
  output logic        smi_req,
  output logic        nmi_req,
  output logic        ext_req,
  output logic        fix_valid,
  output logic [7:0]  fix_vector,
  output logic        fix_level
);
  always_ff @(posedge clk) begin
    if (rst) begin
      smi_req    <= 1'b0;
      nmi_req    <= 1'b0;
      ext_req    <= 1'b0;
      fix_valid  <= 1'b0;
      fix_vector <= '0;
      fix_level  <= 1'b0;
    end else begin
      smi_req    <= 1'b0;
      nmi_req    <= 1'b0;
      ext_req    <= 1'b0;
      fix_valid  <= 1'b0;
      fix_vector <= '0;
      fix_level  <= 1'b0;
      if (go && !entry[MASK_BIT]) begin
        case (entry[10:8])
          DM_SMI:    smi_req <= 1'b1;
          DM_NMI:    nmi_req <= 1'b1;
          DM_EXTINT: ext_req <= 1'b1;
          DM_FIXED: begin
            fix_valid  <= 1'b1;
            fix_vector <= entry[7:0];
            fix_level  <= (src != SRC_TMR) && entry[LEVEL_BIT];
          end
          default: ;
        endcase
      end
    end
  end

  AST_MASK_SILENT: assert property (@(posedge clk) disable iff (rst)
    (go && entry[MASK_BIT]) |=> !(smi_req || nmi_req || ext_req || fix_valid)); // R1

  AST_ONE_OUTPUT: assert property (@(posedge clk) disable iff (rst)
    $onehot0({smi_req, nmi_req, ext_req, fix_valid})); // R3

  AST_QUIET_FIELDS: assert property (@(posedge clk) disable iff (rst)
    !fix_valid |-> (fix_vector == 8'h00 && !fix_level)); // R4
endmodule

// File: rtl/lvt_dispatch.sv
module lvt_dispatch
  import lvt_pkg::*;
#(
  parameter int NUM_ENTRIES = 6,
  parameter int ID_W        = 8,
  localparam int IDX_W      = $clog2(NUM_ENTRIES)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [ID_W-1:0]  cpu_id,
  input  logic             glb_en,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] addr,
  input  logic [31:0]      wr_data,
  output logic [31:0]      rd_data,
  input  logic             tmr_expire,
  input  logic             legacy_req,
  input  logic             lint1_evt,
  output logic             smi_req,
  output logic             nmi_req,
  output logic             ext_req,
  output logic             fix_valid,
  output logic [7:0]       fix_vector,
  output logic             fix_level
);
  logic [31:0] tmr_ent, lint0_ent, lint1_ent, sel_ent;
  logic        lint0_acc, go;
  src_e        src;

  lvt_table #(.NUM_ENTRIES(NUM_ENTRIES), .ID_W(ID_W)) u_table (
    .clk(clk), .rst(rst), .cpu_id(cpu_id), .wr_en(wr_en), .addr(addr),
    .wr_data(wr_data), .rd_data(rd_data), .tmr_ent(tmr_ent),
    .lint0_ent(lint0_ent), .lint1_ent(lint1_ent)
  );

  assign lint0_acc = legacy_req && (!glb_en || !lint0_ent[MASK_BIT]);

  lvt_arbiter #(.NUM_SRC(3)) u_arb (
    .clk(clk), .rst(rst), .tmr_evt(tmr_expire), .lint0_evt(lint0_acc),
    .lint1_evt(lint1_evt), .go(go), .src(src)
  );

  always_comb begin
    case (src)
      SRC_TMR:   sel_ent = tmr_ent;
      SRC_LINT0: sel_ent = lint0_ent;
      default:   sel_ent = lint1_ent;
    endcase
  end

  lvt_decode u_dec (
    .clk(clk), .rst(rst), .go(go), .src(src), .entry(sel_ent),
    .smi_req(smi_req), .nmi_req(nmi_req), .ext_req(ext_req),
    .fix_valid(fix_valid), .fix_vector(fix_vector), .fix_level(fix_level)
  );

  AST_TIMER_EDGE: assert property (@(posedge clk) disable iff (rst)
    (go && src == SRC_TMR) |=> !fix_level); // R5

  AST_LEGACY_IDLE: assert property (@(posedge clk) disable iff (rst)
    (!legacy_req && !tmr_expire && !lint1_evt && !go) |=> !ext_req); // R8
endmodule

// File: tb/lvt_dispatch_test.sv
module lvt_dispatch_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [7:0]  cpu_id = 8'd0;
  logic        glb_en = 1'b0, wr_en = 1'b0;
  logic [2:0]  addr = '0;
  logic [31:0] wr_data = '0, rd_data;
  logic        tmr_expire = 1'b0, legacy_req = 1'b0, lint1_evt = 1'b0;
  logic        smi_req, nmi_req, ext_req, fix_valid, fix_level;
  logic [7:0]  fix_vector;
  int          n_run = 0, n_fail = 0, cyc = 0;

  lvt_dispatch uut (
    .clk(clk), .rst(rst), .cpu_id(cpu_id), .glb_en(glb_en), .wr_en(wr_en),
    .addr(addr), .wr_data(wr_data), .rd_data(rd_data), .tmr_expire(tmr_expire),
    .legacy_req(legacy_req), .lint1_evt(lint1_evt), .smi_req(smi_req),
    .nmi_req(nmi_req), .ext_req(ext_req), .fix_valid(fix_valid),
    .fix_vector(fix_vector), .fix_level(fix_level)
  );

  always #5 clk = ~clk;

  function automatic logic [12:0] outs();
    return {smi_req, nmi_req, ext_req, fix_valid, fix_vector, fix_level};
  endfunction

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(int idx, logic [31:0] d);
    @(negedge clk); wr_en = 1'b1; addr = 3'(idx); wr_data = d;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic rd_check(string req, int idx, logic [31:0] exp);
    @(negedge clk); addr = 3'(idx);
    @(negedge clk); check(req, rd_data, exp);
  endtask

  task automatic fire(logic t, logic l0, logic l1);
    @(negedge clk); tmr_expire = t; legacy_req = l0; lint1_evt = l1;
    @(negedge clk); tmr_expire = 1'b0; legacy_req = 1'b0; lint1_evt = 1'b0;
  endtask

  function automatic logic [12:0] expect_out(int s, int mode, bit mask, bit lvl, logic [7:0] vec);
    if (mask) return '0;
    case (mode)
      2: return 13'b1_0_0_0_00000000_0;
      4: return 13'b0_1_0_0_00000000_0;
      7: return 13'b0_0_1_0_00000000_0;
      0: return {4'b0001, vec, (s != 0) && lvl};
      default: return '0;
    endcase
  endfunction

  initial begin
    while (1) begin
      @(posedge clk); cyc++;
      if (cyc > 100000) begin
        n_fail++;
        $display("FAIL watchdog: actual %0d expected below 100000", cyc);
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
      end
    end
  end

  initial begin
    logic [7:0] v;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R6 reset values with cpu_id zero
    for (int i = 0; i < 6; i++)
      rd_check("R6", i, (i == 3) ? 32'h0000_0700 : 32'h0001_0000);
    check("R3 idle outputs after reset", 32'(outs()), 32'h0);
    // R8 LINT0 boot value is ExtINT unmasked, yet no request means no delivery
    glb_en = 1'b1;
    repeat (4) @(negedge clk);
    check("R8 no request", 32'(outs()), 32'h0);
    fire(1'b0, 1'b1, 1'b0);
    check("R7 accepted legacy via boot LINT0", 32'(outs()), 32'(13'b0_0_1_0_00000000_0));

    // R10 write/readback on spare index
    wr(5, 32'hA5A5_1234);
    rd_check("R10 readback", 5, 32'hA5A5_1234);

    // sweep: sources x modes x mask x level (R1 R2 R4 R5)
    glb_en = 1'b0;
    for (int s = 0; s < 3; s++)
      for (int m = 0; m < 8; m++)
        for (int k = 0; k < 4; k++) begin
          v = 8'(16 * s + 2 * m + k + 8'h20);
          wr((s == 0) ? 0 : (s == 1) ? 3 : 4,
             {15'd0, k[1], k[0], 4'd0, 3'(m), v});
          fire(s == 0, s == 1, s == 2);
          check($sformatf("R1 R2 R4 R5 src%0d mode%0d k%0d", s, m, k),
                32'(outs()), 32'(expect_out(s, m, k[1], k[0], v)));
          @(negedge clk);
          check("R3 single pulse", 32'(outs()), 32'h0);
        end

    // R9 priority burst
    wr(0, 32'h0000_0011); wr(3, 32'h0000_8033); wr(4, 32'h0000_0044);
    glb_en = 1'b1;
    fire(1'b1, 1'b1, 1'b1);
    check("R9 first timer", 32'(outs()), 32'(13'b0001_00010001_0));
    @(negedge clk);
    check("R9 second LINT0", 32'(outs()), 32'(13'b0001_00110011_1));
    @(negedge clk);
    check("R9 third LINT1", 32'(outs()), 32'(13'b0001_01000100_0));
    @(negedge clk);
    check("R9 drained", 32'(outs()), 32'h0);

    // R7 acceptance seen through slot usage
    wr(3, 32'h0001_0000); wr(4, 32'h0000_0055);
    glb_en = 1'b0;
    fire(1'b0, 1'b1, 1'b1);
    check("R7 accepted masked takes slot", 32'(outs()), 32'h0);
    @(negedge clk);
    check("R7 LINT1 delayed", 32'(outs()), 32'(13'b0001_01010101_0));
    glb_en = 1'b1;
    fire(1'b0, 1'b1, 1'b1);
    check("R7 rejected request no slot", 32'(outs()), 32'(13'b0001_01010101_0));
    @(negedge clk);
    check("R7 nothing after", 32'(outs()), 32'h0);

    // R10 write ignored in reset; R6 nonzero cpu_id
    @(negedge clk); rst = 1'b1; cpu_id = 8'd2; wr_en = 1'b1; addr = 3'd1; wr_data = 32'hDEAD_BEEF;
    @(negedge clk); @(negedge clk); wr_en = 1'b0; rst = 1'b0;
    rd_check("R6 LINT0 nonzero id", 3, 32'h0001_0000);
    rd_check("R10 write in reset ignored", 1, 32'h0001_0000);
    rd_check("R6 timer entry", 0, 32'h0001_0000);
    glb_en = 1'b0;
    fire(1'b0, 1'b1, 1'b0);
    check("R1 masked LINT0 after reset", 32'(outs()), 32'h0);

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule